// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. A start request makes it freeze the analog input by asserting a hold command to an external sample-and-hold stage. It then runs a binary search over an N-bit code. Each trial sets one candidate bit and drives the trial code onto an external DAC. One clock later it reads an external comparator and either keeps or drops that bit.

The search runs from the most significant bit down to the least significant bit, one decision per bit. When the last decision is made, the block registers the code, pulses a done strobe for one clock, releases the hold command and drops busy. The DAC, the comparator and the sample-and-hold are analog parts outside the block.

The interface has no valid/ready handshake, because nothing here can stall. Start is a plain request that is only taken while the block is idle. The result is not a stream: it sits in a register and stays valid from the done pulse until the next done pulse. A consumer that misses the strobe can still read the code, so no back-pressure path is needed.

Top module: `sar_ctrl`

## Requirements
- R1: A start accepted at a clock edge makes the trial code on the DAC output, in the following cycle, equal to half of full scale: only bit N-1 is set and all lower bits are clear.
- R2: Each bit trial takes two cycles, a settle cycle followed by a sample cycle. The DAC code stays unchanged across those two cycles. The comparator is sampled only at the edge that ends the sample cycle.
- R3: The comparator input is 1 when the held input exceeds the DAC level. On 1 the bit under test stays 1; on 0 that bit is cleared. The bits already decided are never altered.
- R4: Bits are tried in order from bit N-1 down to bit 0. After bit k is decided, the next trial code keeps the decided upper bits, sets bit k-1 and leaves the lower bits clear.
- R5: A conversion makes exactly N decisions. The done strobe is high in the cycle that starts 2N clock edges after the edge that accepted start.
- R6: The hold command rises together with busy and stays high through the last sample cycle. It is low in the done cycle and whenever the block is idle.
- R7: Busy is high from the cycle after the accepting edge until the done cycle, where it is low. A start seen while busy is ignored. A start held high during the done cycle begins a new conversion at the next edge.
- R8: The done strobe lasts one cycle. In that cycle the result output equals the final searched code, and it stays unchanged until the next done strobe, whatever the comparator does.
- R9: After reset the outputs are low: busy, hold, done, the DAC code and the result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, taken only while idle |
| cmp_i | input | 1 | Comparator: 1 when the held input exceeds the DAC level |
| hold_o | output | 1 | Hold command to the sample-and-hold |
| dac_code_o | output | WIDTH | Trial code driven to the DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle strobe marking a new result |
| code_o | output | WIDTH | Registered conversion result |

## Verification
A start taken at edge E0 is due to show up as follows:
- busy, hold and the half-scale code appear right after E0.
- Each later trial code appears two edges after the previous one.
- done and the result appear right after edge E0+2N.

The bench's reference model steps once per clock edge with the same latencies, and every output is compared against it at the falling edge. Directed checks also count falling edges from the start request to the done strobe and expect exactly 2N+1. The comparator is modelled as a strict greater-than against the DAC code, so an input equal to a trial level clears that bit, and the expected code is worked out by an independent search in the bench.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // Phase of the conversion sequencer.
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_SAMPLE = 2'd2
  } sar_phase_e;

endpackage

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic last_i,
  output logic load_o,
  output logic decide_o,
  output logic finish_o,
  output logic busy_o
);
  import sar_pkg::*;

  sar_phase_e phase_q, phase_d;

  // Start is only taken in the idle phase.
  assign load_o   = (phase_q == PH_IDLE) && start_i;
  assign decide_o = (phase_q == PH_SAMPLE);
  assign finish_o = decide_o && last_i;
  assign busy_o   = (phase_q != PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (start_i) phase_d = PH_SETTLE;
      PH_SETTLE: phase_d = PH_SAMPLE;
      PH_SAMPLE: phase_d = last_i ? PH_IDLE : PH_SETTLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             decide_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic [WIDTH-1:0] final_o,
  output logic             last_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] trial_q, trial_d;
  logic [WIDTH-1:0] ptr_q, ptr_d;
  logic [WIDTH-1:0] decided;

  // Per-bit update: the bit under test takes the comparator, the one below
  // it becomes the next candidate, decided bits keep their value.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign decided[i] = ptr_q[i] ? cmp_i : trial_q[i];
    if (i == MSB) begin : g_top
      always_comb begin
        if (load_i)        trial_d[i] = 1'b1;
        else if (decide_i) trial_d[i] = decided[i];
        else               trial_d[i] = trial_q[i];
        if (load_i)        ptr_d[i] = 1'b1;
        else if (decide_i) ptr_d[i] = 1'b0;
        else               ptr_d[i] = ptr_q[i];
      end
    end else begin : g_low
      always_comb begin
        if (load_i)        trial_d[i] = 1'b0;
        else if (decide_i) trial_d[i] = decided[i] | ptr_q[i+1];
        else               trial_d[i] = trial_q[i];
        if (load_i)        ptr_d[i] = 1'b0;
        else if (decide_i) ptr_d[i] = ptr_q[i+1];
        else               ptr_d[i] = ptr_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trial_q <= '0;
      ptr_q   <= '0;
    end else begin
      trial_q <= trial_d;
      ptr_q   <= ptr_d;
    end
  end

  assign trial_o = trial_q;
  assign final_o = decided;
  assign last_o  = ptr_q[0];

endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             finish_i,
  input  logic [WIDTH-1:0] final_i,
  output logic [WIDTH-1:0] code_o,
  output logic             done_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= finish_i;
      if (finish_i) code_o <= final_i;
    end
  end

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             hold_o,
  output logic [WIDTH-1:0] dac_code_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] code_o
);

  logic             load, decide, finish, last;
  logic [WIDTH-1:0] final_code;

  sar_seq #(.WIDTH(WIDTH)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .last_i   (last),
    .load_o   (load),
    .decide_o (decide),
    .finish_o (finish),
    .busy_o   (busy_o)
  );

  sar_trial #(.WIDTH(WIDTH)) u_trial (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .decide_i (decide),
    .cmp_i    (cmp_i),
    .trial_o  (dac_code_o),
    .final_o  (final_code),
    .last_o   (last)
  );

  sar_result #(.WIDTH(WIDTH)) u_result (
    .clk      (clk),
    .rst_n    (rst_n),
    .finish_i (finish),
    .final_i  (final_code),
    .code_o   (code_o),
    .done_o   (done_o)
  );

  // The input is held for exactly the span of the search.
  assign hold_o = busy_o;

endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             cmp_i,
  input logic             hold_o,
  input logic [WIDTH-1:0] dac_code_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] code_o
);

  localparam int CW = $clog2(2 * WIDTH + 1) + 1;
  localparam logic [WIDTH-1:0] HALF = {1'b1, {(WIDTH-1){1'b0}}};

  logic [CW-1:0] run_q;
  int            bit_idx;

  // Busy cycles elapsed in the current conversion.
  always_ff @(posedge clk) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  always_comb bit_idx = WIDTH - 1 - int'(run_q >> 1);

  assert_half_scale_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> dac_code_o == HALF);

  assert_trial_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && run_q[0]) |-> $stable(dac_code_o));

  assert_bit_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !run_q[0] && bit_idx >= 0) |-> dac_code_o[bit_idx]);

  assert_step_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> int'(run_q) == 2 * WIDTH);

  assert_hold_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_o) |-> done_o);

  assert_start_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_code_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(code_o));

endmodule

bind sar_ctrl sar_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .cmp_i      (cmp_i),
  .hold_o     (hold_o),
  .dac_code_o (dac_code_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .code_o     (code_o)
);

// File: tb/sar_ctrl_tb.sv
`timescale 1ns/1ps
module sar_ctrl_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         cmp;
  logic         hold, busy, done;
  logic [W-1:0] dac, code;
  int           vin = 0;
  int           checks = 0;
  int           errors = 0;
  int           cyc = 0;

  always #2.5 clk = ~clk;

  // Comparator model: strictly greater-than against the DAC level.
  assign cmp = (vin > int'(dac));

  sar_ctrl #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_i(cmp),
    .hold_o(hold), .dac_code_o(dac), .busy_o(busy), .done_o(done), .code_o(code)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int search(input int v);
    int c = 0;
    for (int b = W - 1; b >= 0; b--) begin
      int t = c | (1 << b);
      if (v > t) c = t;
    end
    return c;
  endfunction

  // Behavioural reference, one step per clock edge.
  bit m_busy = 0, m_done = 0;
  int m_trial = 0, m_bit = 0, m_phase = 0, m_code = 0;

  always @(posedge clk) begin : model
    int t;
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_trial <= 0; m_bit <= 0; m_phase <= 0; m_code <= 0;
    end else begin
      m_done <= 0;
      if (!m_busy) begin
        if (start) begin
          m_busy <= 1; m_trial <= 1 << (W - 1); m_bit <= W - 1; m_phase <= 0;
        end
      end else if (m_phase == 0) begin
        m_phase <= 1;
      end else begin
        t = cmp ? m_trial : (m_trial & ~(1 << m_bit));
        if (m_bit == 0) begin
          m_busy <= 0; m_done <= 1; m_code <= t; m_trial <= t;
        end else begin
          m_trial <= t | (1 << (m_bit - 1)); m_bit <= m_bit - 1; m_phase <= 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == m_busy, "R7", "busy", busy, m_busy);
      chk(hold == m_busy, "R6", "hold", hold, m_busy);
      chk(done == m_done, "R5", "done", done, m_done);
      chk(int'(dac) == m_trial, "R2/R3/R4", "dac_code", dac, m_trial);
      chk(int'(code) == m_code, "R8", "code", code, m_code);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic convert(input int v, input bit poke);
    int n;
    int held;
    vin = v;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; n = 1;
    chk(int'(dac) == (1 << (W - 1)), "R1", "first trial", dac, 1 << (W - 1));
    while (!done && n < 4 * W) begin
      @(negedge clk); n++;
      if (poke && n == 5) start = 1'b1;
      if (poke && n == 6) start = 1'b0;
    end
    chk(n == 2 * W + 1, "R5", "latency", n, 2 * W + 1);
    chk(int'(code) == search(v), "R3", "result", code, search(v));
    chk(!busy && !hold, "R6", "idle at done", {busy, hold}, 0);
    held = int'(code);
    vin = (v > 128) ? 0 : 256;
    repeat (4) @(negedge clk);
    chk(int'(code) == held && !done, "R8", "result held", code, held);
    chk(!busy, "R7", "start during busy ignored", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !hold && !done && dac == '0 && code == '0, "R9", "reset state",
        {busy, hold, done, dac, code}, 0);
    rst_n = 1'b1;
    convert(0, 0);
    convert(256, 0);
    convert(128, 0);
    convert(127, 1);
    convert(129, 0);
    convert(85, 1);
    convert(170, 0);
    // Start held across the done cycle: a second conversion follows at once.
    vin = 200;
    @(negedge clk); start = 1'b1;
    while (!done) @(negedge clk);
    chk(int'(code) == search(200), "R4", "back-to-back first", code, search(200));
    vin = 33;
    @(negedge clk); start = 1'b0;
    chk(busy, "R7", "restart after done", busy, 1);
    while (!done) @(negedge clk);
    chk(int'(code) == search(33), "R4", "back-to-back second", code, search(33));
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule